// File: doc/BRIEF.md
# Slot-Multiplexed Interrupt Level Requester

This block lets a peripheral on a shared on-chip module bus raise an interrupt at any one of 32 priority levels. It does this with only eight request lines. The bus cycles through four time slots and announces the current one on a 2-bit slot indicator. Each group of eight levels belongs to one slot, so a level is sent by driving one line while its slot is current.

The block serves two interrupt sources: a serial communications channel and a queued serial peripheral channel. Each source has a 5-bit level register, which only supervisor-mode software may program. The upper two bits of a level pick the slot and the lower three pick the line. Each cycle, every pending source with a nonzero level is decoded against the current slot. The decoded lines are merged and driven out through a register.

A small register port handles all accesses locally and answers each one with either an acknowledge or a bus error. A user-mode access to a supervisor-only register is answered the same way as an access to an unmapped address.

Top module: `irq_level_requester`

## Requirements
- R1: While reset is held and after it is released, both level registers read 0, the request lines are inactive (all 0 active-high, all 1 when inverted), and bus_ack and bus_err are 0.
- R2: For a pending source with level n (n nonzero), line n mod 8 is asserted one clock after bus_slot equals n div 8. The slot is level bits [4:3] and the line is level bits [2:0].
- R3: A pending source drives no line while bus_slot differs from its level's slot.
- R4: A source whose pending input is low drives no line.
- R5: A level of 0 keeps the source silent, even when it is pending and bus_slot is 00.
- R6: When both sources are pending and their levels share a slot, the request lines are the OR of both decoded lines.
- R7: When the two pending sources have levels in different slots, each source's line appears only during its own slot.
- R8: In supervisor mode (bus_user=0), address 0 holds the serial-channel level and address 1 holds the queued-channel level. A write stores bus_wdata[4:0]. A read returns the level in bus_rdata[4:0] with the upper bits at 0. bus_ack pulses one clock after the request.
- R9: A user-mode (bus_user=1) access to address 0 or 1 gives bus_err one clock later, with no bus_ack. A user-mode write to either address leaves the level unchanged.
- R10: Address 2 can be read in either mode. It returns the active-high request-line pattern as registered before the access, and it is acknowledged. A write to address 2 is acknowledged and has no effect.
- R11: An access to address 3 gives bus_err one clock later in either mode.
- R12: With ACTIVE_LOW=1, irq_lines is the bitwise inverse of the active-high pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_slot | input | 2 | Current time slot announced by the bus |
| src_pend | input | 2 | Pending flags; bit 0 is the serial channel, bit 1 is the queued channel |
| bus_req | input | 1 | Register access strobe, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_ack | output | 1 | Access accepted, one clock after the request |
| bus_err | output | 1 | Access refused, one clock after the request |
| bus_rdata | output | 8 | Read data, valid with bus_ack |
| irq_lines | output | 8 | Registered interrupt request lines |

## Verification
Every result arrives one clock after its stimulus. The request lines are registered once from bus_slot, src_pend and the levels. The access response and the read data are registered once from the request. The bench changes inputs on the falling edge and samples on the next falling edge, so exactly one rising edge separates each stimulus from its check. For an address-2 read, the bench first lets the request lines settle for one clock and only then issues the access, because that read returns the previously registered line pattern.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_OK    = 2'd1,
    ACC_FAULT = 2'd2
  } acc_e;
endpackage

// File: rtl/irq_slot_decoder.sv
module irq_slot_decoder #(
  parameter int NUM_LINES = 8,
  parameter int SLOT_W    = 2,
  parameter int LINE_W    = $clog2(NUM_LINES),
  parameter int LEVEL_W   = SLOT_W + LINE_W
) (
  input  logic [LEVEL_W-1:0]   level,
  input  logic                 pend,
  input  logic [SLOT_W-1:0]    slot,
  output logic [NUM_LINES-1:0] lines_o
);
  logic hit;

  always_comb begin
    hit = pend && (level != '0) && (level[LEVEL_W-1 -: SLOT_W] == slot);
    lines_o = '0;
    if (hit) lines_o[level[LINE_W-1:0]] = 1'b1;
  end
endmodule

// File: rtl/irq_level_regs.sv
module irq_level_regs
  import irq_pkg::*;
#(
  parameter int NUM_SRC   = 2,
  parameter int LEVEL_W   = 5,
  parameter int DATA_W    = 8,
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = $clog2(NUM_SRC + 2)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_req,
  input  logic                       bus_we,
  input  logic                       bus_user,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic [NUM_LINES-1:0]       line_view,
  output logic                       bus_ack,
  output logic                       bus_err,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic [NUM_SRC*LEVEL_W-1:0] levels_o
);
  localparam logic [ADDR_W-1:0] VIEW_ADDR = ADDR_W'(NUM_SRC);

  logic [LEVEL_W-1:0] lvl_q [NUM_SRC];
  acc_e               outcome;
  logic [DATA_W-1:0]  rd_next;
  logic               is_lvl;

  always_comb begin
    is_lvl  = bus_addr < VIEW_ADDR;
    outcome = ACC_IDLE;
    rd_next = '0;
    if (bus_req) begin
      if (is_lvl && !bus_user) begin
        outcome = ACC_OK;
        for (int s = 0; s < NUM_SRC; s++)
          if (bus_addr == ADDR_W'(s)) rd_next[LEVEL_W-1:0] = lvl_q[s];
      end else if (bus_addr == VIEW_ADDR) begin
        outcome = ACC_OK;
        rd_next[NUM_LINES-1:0] = line_view;
      end else begin
        outcome = ACC_FAULT;
      end
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (rst) lvl_q[s] <= '0;
      else if (bus_req && bus_we && !bus_user && bus_addr == ADDR_W'(s))
        lvl_q[s] <= bus_wdata[LEVEL_W-1:0];
    end
    assign levels_o[s*LEVEL_W +: LEVEL_W] = lvl_q[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= (outcome == ACC_OK);
      bus_err   <= (outcome == ACC_FAULT);
      bus_rdata <= (outcome == ACC_OK && !bus_we) ? rd_next : '0;
    end
  end

  // R8: the two responses never appear together
  p_ack_err_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(bus_ack && bus_err));

  // R9: user access to a level register is refused on the next clock
  p_user_refused_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_user && bus_addr < VIEW_ADDR) |=> (bus_err && !bus_ack));

  // R9: a user write leaves the stored levels untouched
  p_user_no_write_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_user && bus_we) |=> $stable(levels_o));

  // R11: addresses beyond the status view are refused in any mode
  p_unmapped_err_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_addr > VIEW_ADDR) |=> bus_err);
endmodule

// File: rtl/irq_level_requester.sv
module irq_level_requester #(
  parameter int NUM_LINES  = 8,
  parameter int NUM_SLOTS  = 4,
  parameter int NUM_SRC    = 2,
  parameter int DATA_W     = 8,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           bus_slot,
  input  logic [1:0]           src_pend,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic                 bus_user,
  input  logic [1:0]           bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic                 bus_ack,
  output logic                 bus_err,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_LINES-1:0] irq_lines
);
  localparam int SLOT_W  = $clog2(NUM_SLOTS);
  localparam int LINE_W  = $clog2(NUM_LINES);
  localparam int LEVEL_W = SLOT_W + LINE_W;
  localparam int ADDR_W  = $clog2(NUM_SRC + 2);

  logic [NUM_SRC*LEVEL_W-1:0]   lvl_flat;
  logic [NUM_LINES-1:0]         src_lines [NUM_SRC];
  logic [NUM_LINES-1:0]         merged;
  logic [NUM_LINES-1:0]         lines_q;
  logic [SLOT_W-1:0]            slot_in;
  logic [NUM_SRC-1:0]           pend_in;
  logic [ADDR_W-1:0]            addr_in;

  assign slot_in = SLOT_W'(bus_slot);
  assign pend_in = NUM_SRC'(src_pend);
  assign addr_in = ADDR_W'(bus_addr);

  irq_level_regs #(
    .NUM_SRC(NUM_SRC), .LEVEL_W(LEVEL_W), .DATA_W(DATA_W),
    .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)
  ) regs_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_user(bus_user), .bus_addr(addr_in), .bus_wdata(bus_wdata),
    .line_view(lines_q), .bus_ack(bus_ack), .bus_err(bus_err),
    .bus_rdata(bus_rdata), .levels_o(lvl_flat)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_dec
    irq_slot_decoder #(
      .NUM_LINES(NUM_LINES), .SLOT_W(SLOT_W), .LINE_W(LINE_W), .LEVEL_W(LEVEL_W)
    ) dec_i (
      .level(lvl_flat[s*LEVEL_W +: LEVEL_W]), .pend(pend_in[s]),
      .slot(slot_in), .lines_o(src_lines[s])
    );
  end

  always_comb begin
    merged = '0;
    for (int s = 0; s < NUM_SRC; s++) merged = merged | src_lines[s];
  end

  always_ff @(posedge clk) begin
    if (rst) lines_q <= '0;
    else     lines_q <= merged;
  end

  if (ACTIVE_LOW) begin : g_inv
    assign irq_lines = ~lines_q;
  end else begin : g_pass
    assign irq_lines = lines_q;
  end

  // R4: no pending source on the previous clock means no line now
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    $past(pend_in == '0) |-> (lines_q == '0));

  // R5: with every level at zero the lines stay low
  p_zero_level_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    $past(lvl_flat == '0) |-> (lines_q == '0));

  // R2: a single pending source raises at most one line
  p_single_line_r2: assert property (@(posedge clk) disable iff (rst)
    ($past($countones(pend_in)) <= 1) |-> $onehot0(lines_q));
endmodule

// File: tb/irq_level_requester_tb.sv
module irq_level_requester_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_slot = '0;
  logic [1:0] src_pend = '0;
  logic       bus_req = 1'b0, bus_we = 1'b0, bus_user = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_ack, bus_err, ack_n, err_n;
  logic [7:0] bus_rdata, irq_lines, rdata_n, irq_n;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #5ns clk = ~clk;

  irq_level_requester dut_i (
    .clk(clk), .rst(rst), .bus_slot(bus_slot), .src_pend(src_pend),
    .bus_req(bus_req), .bus_we(bus_we), .bus_user(bus_user),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_err(bus_err), .bus_rdata(bus_rdata), .irq_lines(irq_lines)
  );

  irq_level_requester #(.ACTIVE_LOW(1'b1)) dut_n (
    .clk(clk), .rst(rst), .bus_slot(bus_slot), .src_pend(src_pend),
    .bus_req(bus_req), .bus_we(bus_we), .bus_user(bus_user),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(ack_n),
    .bus_err(err_n), .bus_rdata(rdata_n), .irq_lines(irq_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic user, input logic we, input logic [1:0] addr,
                        input logic [7:0] wd, output logic ack, output logic err,
                        output logic [7:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_user = user; bus_addr = addr; bus_wdata = wd;
    @(negedge clk);
    ack = bus_ack; err = bus_err; rd = bus_rdata;
    bus_req = 1'b0; bus_we = 1'b0; bus_user = 1'b0;
  endtask

  task automatic drive(input logic [1:0] slot, input logic [1:0] pend);
    @(negedge clk);
    bus_slot = slot; src_pend = pend;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic a, e; logic [7:0] d;
    chk("R1 lines", irq_lines, 8'h00);
    chk("R1 inverted lines", irq_n, 8'hFF);
    chk("R1 ack", bus_ack, 0);
    chk("R1 err", bus_err, 0);
    access(0, 0, 2'd0, 0, a, e, d); chk("R1 level0 reads 0", d, 8'h00);
    access(0, 0, 2'd1, 0, a, e, d); chk("R1 level1 reads 0", d, 8'h00);
  endtask

  task automatic t_regs();
    logic a, e; logic [7:0] d;
    access(0, 1, 2'd0, 8'hED, a, e, d); chk("R8 write ack", {a, e}, 2'b10);
    access(0, 0, 2'd0, 0, a, e, d);     chk("R8 read ack", {a, e}, 2'b10);
    chk("R8 level0 readback", d, 8'h0D);
    access(0, 1, 2'd1, 8'h14, a, e, d);
    access(0, 0, 2'd1, 0, a, e, d);     chk("R8 level1 readback", d, 8'h14);
  endtask

  task automatic t_user();
    logic a, e; logic [7:0] d;
    access(1, 1, 2'd0, 8'h09, a, e, d); chk("R9 user write refused", {a, e}, 2'b01);
    access(1, 0, 2'd1, 0, a, e, d);     chk("R9 user read refused", {a, e}, 2'b01);
    access(0, 0, 2'd0, 0, a, e, d);     chk("R9 level unchanged", d, 8'h0D);
  endtask

  task automatic t_unmapped();
    logic a, e; logic [7:0] d;
    access(0, 0, 2'd3, 0, a, e, d); chk("R11 supervisor addr3", {a, e}, 2'b01);
    access(1, 1, 2'd3, 8'hFF, a, e, d); chk("R11 user addr3", {a, e}, 2'b01);
  endtask

  task automatic t_decode();
    drive(2'd1, 2'b01); chk("R2 level 13 on slot 1", irq_lines, 8'h20);
    chk("R12 inverted", irq_n, 8'hDF);
    drive(2'd0, 2'b01); chk("R3 slot 0 quiet", irq_lines, 8'h00);
    drive(2'd2, 2'b01); chk("R3 slot 2 quiet", irq_lines, 8'h00);
    drive(2'd3, 2'b01); chk("R3 slot 3 quiet", irq_lines, 8'h00);
    drive(2'd1, 2'b00); chk("R4 not pending", irq_lines, 8'h00);
  endtask

  task automatic t_view();
    logic a, e; logic [7:0] d;
    drive(2'd1, 2'b01);
    access(1, 0, 2'd2, 0, a, e, d);
    chk("R10 user view ack", {a, e}, 2'b10);
    chk("R10 view pattern", d, 8'h20);
    access(1, 1, 2'd2, 8'h55, a, e, d); chk("R10 view write ack", {a, e}, 2'b10);
    chk("R10 write no effect on lines", irq_lines, 8'h20);
    access(0, 0, 2'd0, 0, a, e, d); chk("R10 level kept", d, 8'h0D);
  endtask

  task automatic t_merge();
    logic a, e; logic [7:0] d;
    access(0, 1, 2'd1, 8'h0A, a, e, d);
    drive(2'd1, 2'b11); chk("R6 same slot OR", irq_lines, 8'h24);
    access(0, 1, 2'd1, 8'h14, a, e, d);
    drive(2'd1, 2'b11); chk("R7 slot 1 only source 0", irq_lines, 8'h20);
    drive(2'd2, 2'b11); chk("R7 slot 2 only source 1", irq_lines, 8'h10);
  endtask

  task automatic t_zero();
    logic a, e; logic [7:0] d;
    access(0, 1, 2'd0, 8'h00, a, e, d);
    access(0, 1, 2'd1, 8'h00, a, e, d);
    drive(2'd0, 2'b11); chk("R5 level 0 silent", irq_lines, 8'h00);
    access(0, 1, 2'd0, 8'h01, a, e, d);
    drive(2'd0, 2'b01); chk("R2 level 1 on slot 0", irq_lines, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_user();
    t_unmapped();
    t_decode();
    t_view();
    t_merge();
    t_zero();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #200us;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule